// File: doc/BRIEF.md
# Deferred Transaction Tracker

This block sits on the request side of a bus bridge. Each strobed request from the originating bus is sorted into one of three classes. Posted traffic is taken at once. Transactions addressed to the bridge's own configuration space are answered immediately. Everything that must reach the far bus first is deferred.

A deferred request occupies the single tracking entry. It is answered with a retry, or with a split response when the bus runs in the PCI-X-style protocol. It is then handed to the destination side with a one-cycle forward strobe. The originator keeps repeating the same request. Each repeat is retried until the destination reports completion. The next matching repeat is then accepted and flagged as the completion hit, and the entry is released one cycle later.

Bus timing, data movement and address decoding lie outside the block. It sees only the command, the configuration flags, the bus mode, the address and the byte enables.

Top module: `defer_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, acc_now, retry, split_rsp, fwd_req and cpl_hit are all low and the entry is free.
- R2: Command codes are 4'h2 I/O read, 4'h3 I/O write, 4'h6 memory read, 4'hE memory read line, 4'hC memory read multiple, 4'h8 memory read DWORD, 4'h9 memory read block, 4'hA config read and 4'hB config write. A config write with cfg_type1=0, for_bridge=1 and on_primary=1 is immediate. A config read with cfg_type1=0 and on_primary=1 is immediate. An immediate request gives acc_now=1 in the cycle after the strobe, with no forward.
- R3: Any code not listed in R2 (for example 4'h7 memory write) gives acc_now=1 in the cycle after the strobe. It never touches the entry.
- R4: Every other request with a code listed in R2 is deferred. If the entry is free, the request is stored. fwd_req is high for exactly one cycle, the cycle after the strobe, and fwd_cmd, fwd_addr and fwd_be show the stored request.
- R5: The first answer to a deferred request is split_rsp when pcix_mode=1 and the code is not 4'h6, 4'hE or 4'hC. In all other cases the first answer is retry.
- R6: A repeat of the stored request (same code, address and byte enables) before the destination has completed is answered with retry.
- R7: After dst_done has been sampled while the entry waits on the destination, the next matching repeat gives acc_now=1 and cpl_hit=1 in the cycle after its strobe.
- R8: A deferred request that does not match the occupied entry is answered with retry. It raises no fwd_req, and fwd_cmd, fwd_addr and fwd_be stay unchanged.
- R9: The entry is released one cycle after the completion is delivered. A deferred request strobed in the cycle right after the completing strobe is retried without being stored. A request in the cycle after that is stored.
- R10: dst_done has no effect unless the entry is waiting on the destination. A dst_done sampled while the entry is free or already completed does not let a later repeat complete.
- R11: At most one of acc_now, retry and split_rsp is high in any cycle. All responses appear in the cycle after the strobe that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one per attempt |
| req_cmd | input | 4 | Bus command code |
| cfg_type1 | input | 1 | Config access is type 1 (0 = type 0) |
| for_bridge | input | 1 | Request targets the bridge itself |
| on_primary | input | 1 | Request arrives on the primary side |
| pcix_mode | input | 1 | Originating bus runs the PCI-X-style protocol |
| req_addr | input | ADDR_W | Request address |
| req_be | input | BE_W | Request byte enables |
| dst_done | input | 1 | Destination side has completed the forwarded request |
| acc_now | output | 1 | Request accepted this attempt |
| retry | output | 1 | Request must be retried |
| split_rsp | output | 1 | Request answered with a split response |
| fwd_req | output | 1 | One-cycle strobe handing the entry to the destination |
| fwd_cmd | output | 4 | Stored command |
| fwd_addr | output | ADDR_W | Stored address |
| fwd_be | output | BE_W | Stored byte enables |
| cpl_hit | output | 1 | Repeat matched a completed entry and was accepted |

## Verification
The assertions assume that dst_done is meaningful only while an entry is outstanding. They also assume that req_valid, together with its qualifiers, is held for a single cycle per attempt. The checker therefore follows outstanding work from fwd_req and dst_done alone, and treats cpl_hit as legal only after a destination completion following the last forward. The stimulus drives every input on the falling edge. It draws addresses and byte enables from a small pool so that matching repeats happen often. It also raises dst_done at random in every state, including free and completed, so that stray completions get exercised.

// File: rtl/defer_tracker_pkg.sv
package defer_tracker_pkg;
   localparam int CMD_W = 4;

   localparam logic [CMD_W-1:0] CMD_IO_RD   = 4'h2;
   localparam logic [CMD_W-1:0] CMD_IO_WR   = 4'h3;
   localparam logic [CMD_W-1:0] CMD_MEM_RD  = 4'h6;
   localparam logic [CMD_W-1:0] CMD_RD_DW   = 4'h8;
   localparam logic [CMD_W-1:0] CMD_RD_BLK  = 4'h9;
   localparam logic [CMD_W-1:0] CMD_CFG_RD  = 4'hA;
   localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'hB;
   localparam logic [CMD_W-1:0] CMD_RD_MULT = 4'hC;
   localparam logic [CMD_W-1:0] CMD_RD_LINE = 4'hE;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PENDING_DEST,
      ST_DEST_DONE,
      ST_COMPLETE
   } entry_state_e;

   typedef enum logic [1:0] {
      CLS_PASS,
      CLS_IMMEDIATE,
      CLS_DEFER
   } req_class_e;
endpackage

// File: rtl/defer_classify.sv
module defer_classify
   import defer_tracker_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   input  logic             cfg_type1,
   input  logic             for_bridge,
   input  logic             on_primary,
   input  logic             pcix_mode,
   output req_class_e       cls,
   output logic             use_split
);
   logic tracked;
   logic conv_read;
   logic imm_cfg_wr;
   logic imm_cfg_rd;

   always_comb begin
      unique case (cmd)
         CMD_IO_RD, CMD_IO_WR, CMD_MEM_RD, CMD_RD_DW, CMD_RD_BLK,
         CMD_CFG_RD, CMD_CFG_WR, CMD_RD_MULT, CMD_RD_LINE: tracked = 1'b1;
         default: tracked = 1'b0;
      endcase
   end

   // legacy read commands keep delayed handling even in PCI-X-style mode
   assign conv_read  = (cmd == CMD_MEM_RD) || (cmd == CMD_RD_LINE) || (cmd == CMD_RD_MULT);
   assign imm_cfg_wr = (cmd == CMD_CFG_WR) && !cfg_type1 && for_bridge && on_primary;
   assign imm_cfg_rd = (cmd == CMD_CFG_RD) && !cfg_type1 && on_primary;

   always_comb begin
      if (!tracked)                      cls = CLS_PASS;
      else if (imm_cfg_wr || imm_cfg_rd) cls = CLS_IMMEDIATE;
      else                               cls = CLS_DEFER;
   end

   assign use_split = pcix_mode && !conv_read;
endmodule

// File: rtl/defer_entry.sv
module defer_entry
   import defer_tracker_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BE_W     = 4,
   parameter bit MATCH_BE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CMD_W-1:0]  in_cmd,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [BE_W-1:0]   in_be,
   output logic [CMD_W-1:0]  held_cmd,
   output logic [ADDR_W-1:0] held_addr,
   output logic [BE_W-1:0]   held_be,
   output logic              same_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_cmd  <= '0;
         held_addr <= '0;
         held_be   <= '0;
      end else if (load) begin
         held_cmd  <= in_cmd;
         held_addr <= in_addr;
         held_be   <= in_be;
      end
   end

   logic key_eq;
   assign key_eq = (in_cmd == held_cmd) && (in_addr == held_addr);

   generate
      if (MATCH_BE) begin : g_be_cmp
         assign same_req = key_eq && (in_be == held_be);
      end else begin : g_no_be_cmp
         assign same_req = key_eq;
      end
   endgenerate
endmodule

// File: rtl/defer_fsm.sv
module defer_fsm
   import defer_tracker_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  req_class_e cls,
   input  logic       use_split,
   input  logic       same_req,
   input  logic       dst_done,
   output logic       load,
   output logic       acc_now,
   output logic       retry,
   output logic       split_rsp,
   output logic       fwd_req,
   output logic       cpl_hit
);
   entry_state_e st_q, st_d;
   logic acc_d, retry_d, split_d, fwd_d, cpl_d;

   always_comb begin
      st_d    = st_q;
      load    = 1'b0;
      acc_d   = 1'b0;
      retry_d = 1'b0;
      split_d = 1'b0;
      fwd_d   = 1'b0;
      cpl_d   = 1'b0;

      if (st_q == ST_COMPLETE)                  st_d = ST_IDLE;
      if (st_q == ST_PENDING_DEST && dst_done)  st_d = ST_DEST_DONE;

      if (req_valid) begin
         if (cls != CLS_DEFER) begin
            acc_d = 1'b1;
         end else if (st_q == ST_IDLE) begin
            load    = 1'b1;
            fwd_d   = 1'b1;
            st_d    = ST_PENDING_DEST;
            split_d = use_split;
            retry_d = !use_split;
         end else if (st_q == ST_DEST_DONE && same_req) begin
            acc_d = 1'b1;
            cpl_d = 1'b1;
            st_d  = ST_COMPLETE;
         end else begin
            retry_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         acc_now   <= 1'b0;
         retry     <= 1'b0;
         split_rsp <= 1'b0;
         fwd_req   <= 1'b0;
         cpl_hit   <= 1'b0;
      end else begin
         st_q      <= st_d;
         acc_now   <= acc_d;
         retry     <= retry_d;
         split_rsp <= split_d;
         fwd_req   <= fwd_d;
         cpl_hit   <= cpl_d;
      end
   end
endmodule

// File: rtl/defer_tracker.sv
module defer_tracker
   import defer_tracker_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BE_W     = 4,
   parameter bit MATCH_BE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_cmd,
   input  logic              cfg_type1,
   input  logic              for_bridge,
   input  logic              on_primary,
   input  logic              pcix_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic              dst_done,
   output logic              acc_now,
   output logic              retry,
   output logic              split_rsp,
   output logic              fwd_req,
   output logic [3:0]        fwd_cmd,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [BE_W-1:0]   fwd_be,
   output logic              cpl_hit
);
   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
         $error("defer_tracker: ADDR_W must lie in 2..64");
      end
      if (BE_W < 1 || BE_W > 16) begin : g_bad_be
         $error("defer_tracker: BE_W must lie in 1..16");
      end
   endgenerate

   req_class_e cls;
   logic use_split, same_req, load;

   defer_classify u_cls (
      .cmd        (req_cmd),
      .cfg_type1  (cfg_type1),
      .for_bridge (for_bridge),
      .on_primary (on_primary),
      .pcix_mode  (pcix_mode),
      .cls        (cls),
      .use_split  (use_split)
   );

   defer_entry #(.ADDR_W(ADDR_W), .BE_W(BE_W), .MATCH_BE(MATCH_BE)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .in_cmd    (req_cmd),
      .in_addr   (req_addr),
      .in_be     (req_be),
      .held_cmd  (fwd_cmd),
      .held_addr (fwd_addr),
      .held_be   (fwd_be),
      .same_req  (same_req)
   );

   defer_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .cls       (cls),
      .use_split (use_split),
      .same_req  (same_req),
      .dst_done  (dst_done),
      .load      (load),
      .acc_now   (acc_now),
      .retry     (retry),
      .split_rsp (split_rsp),
      .fwd_req   (fwd_req),
      .cpl_hit   (cpl_hit)
   );
endmodule

// File: rtl/defer_tracker_chk.sv
module defer_tracker_chk #(
   parameter int ADDR_W = 32,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dst_done,
   input logic              acc_now,
   input logic              retry,
   input logic              split_rsp,
   input logic              fwd_req,
   input logic [3:0]        fwd_cmd,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic [BE_W-1:0]   fwd_be,
   input logic              cpl_hit
);
   // observed occupancy, rebuilt from the ports only
   logic busy_q, dest_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         dest_seen_q <= 1'b0;
      end else if (fwd_req) begin
         busy_q      <= 1'b1;
         dest_seen_q <= dst_done;
      end else begin
         if (busy_q && dst_done) dest_seen_q <= 1'b1;
         if (cpl_hit) begin
            busy_q      <= 1'b0;
            dest_seen_q <= 1'b0;
         end
      end
   end

   AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_req |=> !fwd_req);                                            // R4
   AST_FWD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_req |-> (retry || split_rsp));                                // R5
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_req |-> $stable({fwd_cmd, fwd_addr, fwd_be}));               // R8
   AST_CPL_AFTER_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_hit |-> (busy_q && dest_seen_q));                             // R7
   AST_CPL_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_hit |-> acc_now);                                             // R7
   AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_req |-> !busy_q);                                             // R9
   AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acc_now, retry, split_rsp}));                           // R11
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> !(acc_now || retry || split_rsp || fwd_req || cpl_hit)); // R1
endmodule

bind defer_tracker defer_tracker_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dst_done  (dst_done),
   .acc_now   (acc_now),
   .retry     (retry),
   .split_rsp (split_rsp),
   .fwd_req   (fwd_req),
   .fwd_cmd   (fwd_cmd),
   .fwd_addr  (fwd_addr),
   .fwd_be    (fwd_be),
   .cpl_hit   (cpl_hit)
);

// File: tb/defer_tracker_test.sv
module defer_tracker_test;
   localparam int AW = 32;
   localparam int BW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [3:0] req_cmd = '0;
   logic cfg_type1 = 1'b0, for_bridge = 1'b0, on_primary = 1'b0, pcix_mode = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] req_be = '0;
   logic dst_done = 1'b0;
   logic acc_now, retry, split_rsp, fwd_req, cpl_hit;
   logic [3:0] fwd_cmd;
   logic [AW-1:0] fwd_addr;
   logic [BW-1:0] fwd_be;

   always #5 clk = ~clk;

   defer_tracker #(.ADDR_W(AW), .BE_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .cfg_type1(cfg_type1), .for_bridge(for_bridge), .on_primary(on_primary),
      .pcix_mode(pcix_mode), .req_addr(req_addr), .req_be(req_be),
      .dst_done(dst_done), .acc_now(acc_now), .retry(retry), .split_rsp(split_rsp),
      .fwd_req(fwd_req), .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr), .fwd_be(fwd_be),
      .cpl_hit(cpl_hit)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 0;

   // reference model: 0 free, 1 waiting on destination, 2 destination done, 3 delivered
   int m_st = 0;
   logic [3:0] m_cmd = '0;
   logic [AW-1:0] m_addr = '0;
   logic [BW-1:0] m_be = '0;

   function automatic bit is_listed(input logic [3:0] c);
      return c inside {4'h2, 4'h3, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE};
   endfunction

   function automatic bit is_immediate(input logic [3:0] c, input logic t1, input logic fb,
                                       input logic pr);
      if (c == 4'hB) return !t1 && fb && pr;
      if (c == 4'hA) return !t1 && pr;
      return 1'b0;
   endfunction

   function automatic bit wants_split(input logic [3:0] c, input logic px);
      return px && !(c inside {4'h6, 4'hE, 4'hC});
   endfunction

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {acc,retry,split,fwd,cpl} actual %b expected %b at %0t",
                  tag, act, exp, $time);
      end
   endtask

   task automatic apply(input logic v, input logic [3:0] c, input logic t1, input logic fb,
                        input logic pr, input logic px, input logic [AW-1:0] a,
                        input logic [BW-1:0] b, input logic dd);
      logic [4:0] exp;
      string tag;
      int nxt;
      bit hold_chk;
      @(negedge clk);
      req_valid = v; req_cmd = c; cfg_type1 = t1; for_bridge = fb;
      on_primary = pr; pcix_mode = px; req_addr = a; req_be = b; dst_done = dd;
      exp = 5'b0; tag = "R11"; nxt = m_st; hold_chk = 1'b0;
      if (m_st == 3) nxt = 0;
      if (m_st == 1 && dd) nxt = 2;
      if (v) begin
         if (!is_listed(c)) begin
            exp[4] = 1'b1; tag = "R3";
         end else if (is_immediate(c, t1, fb, pr)) begin
            exp[4] = 1'b1; tag = "R2";
         end else if (m_st == 0) begin
            exp[1] = 1'b1;
            if (wants_split(c, px)) exp[2] = 1'b1; else exp[3] = 1'b1;
            tag = "R4 R5"; nxt = 1;
            m_cmd = c; m_addr = a; m_be = b;
         end else if (m_st == 2 && c == m_cmd && a == m_addr && b == m_be) begin
            exp[4] = 1'b1; exp[0] = 1'b1; tag = "R7"; nxt = 3;
         end else begin
            exp[3] = 1'b1; hold_chk = 1'b1;
            tag = (m_st == 3) ? "R9" : (c == m_cmd && a == m_addr && b == m_be) ? "R6 R10" : "R8";
         end
      end
      @(posedge clk); #1;
      check(tag, {acc_now, retry, split_rsp, fwd_req, cpl_hit}, exp);
      if (exp[1] || hold_chk) begin
         n_vec++;
         if ({fwd_cmd, fwd_addr, fwd_be} !== {m_cmd, m_addr, m_be}) begin
            n_bad++;
            $display("FAIL %s: held entry actual %h/%h/%h expected %h/%h/%h", tag,
                     fwd_cmd, fwd_addr, fwd_be, m_cmd, m_addr, m_be);
         end
      end
      m_st = nxt;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [AW-1:0] pool_a [4];
      logic [3:0] cmds [12];
      void'($urandom(32'd1234));
      pool_a = '{32'h100, 32'h104, 32'h2000, 32'h100};
      cmds = '{4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'h1, 4'h3};

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", {acc_now, retry, split_rsp, fwd_req, cpl_hit}, 5'b0);
      @(negedge clk); rst_n = 1'b1;
      apply(0, 4'h0, 0, 0, 0, 0, '0, '0, 0);

      // R2 immediate config cases, R3 pass-through
      apply(1, 4'hB, 0, 1, 1, 1, 32'h10, 4'hF, 0);
      apply(1, 4'hA, 0, 0, 1, 0, 32'h10, 4'hF, 0);
      apply(1, 4'h7, 0, 0, 0, 1, 32'h40, 4'h3, 0);
      // R10: stray completion while free
      apply(0, 4'h0, 0, 0, 0, 0, '0, '0, 1);
      // R4 R5: I/O write in PCI-X-style mode gets split
      apply(1, 4'h3, 0, 0, 1, 1, 32'h300, 4'h1, 0);
      // R6 repeat, R8 other request
      apply(1, 4'h3, 0, 0, 1, 1, 32'h300, 4'h1, 0);
      apply(1, 4'h2, 0, 0, 1, 1, 32'h304, 4'h1, 0);
      // R2 immediate still served while occupied
      apply(1, 4'hB, 0, 1, 1, 0, 32'h8, 4'hF, 0);
      // destination done, then R7 completion
      apply(0, 4'h0, 0, 0, 0, 0, '0, '0, 1);
      apply(1, 4'h3, 0, 0, 1, 1, 32'h300, 4'h1, 0);
      // R9: release takes one cycle; R10: completion during delivery ignored
      apply(1, 4'h6, 0, 0, 1, 1, 32'h500, 4'hF, 1);
      // R5: memory read in PCI-X-style mode gets retry
      apply(1, 4'h6, 0, 0, 1, 1, 32'h500, 4'hF, 0);
      apply(1, 4'h6, 0, 0, 1, 1, 32'h500, 4'hF, 0);
      apply(0, 4'h0, 0, 0, 0, 0, '0, '0, 1);
      apply(1, 4'h6, 0, 0, 1, 1, 32'h500, 4'hE, 0);
      apply(1, 4'h6, 0, 0, 1, 1, 32'h500, 4'hF, 0);
      // type 0 config write on secondary side is deferred
      apply(1, 4'hB, 0, 1, 0, 0, 32'h20, 4'hF, 0);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         apply(r[0] | r[1], cmds[r[5:2] % 12], r[6], r[7], r[8], r[9],
               pool_a[r[11:10]], {2'b00, r[12], 1'b1}, (r[15:13] < 3'd2));
      end

      apply(0, 4'h0, 0, 0, 0, 0, '0, '0, 0);
      finish_run();
   end
endmodule